// File: doc/BRIEF.md
# Vectored Trap Target Unit

This block is the trap-entry corner of a machine-mode hart. It holds three control registers: a trap-vector register that carries an aligned handler base address and a two-bit mode field, an interrupt-enable register, and an interrupt-pending register. It collects the live timer, software and external interrupt lines together with one writable supervisor software pending bit. It masks them with the enable bits and a global interrupt enable, and picks one winner by fixed priority. When a trap is taken it produces the cause value and the program counter at which the handler starts.

A synchronous exception request always wins over any interrupt in the same cycle, and it always lands on the base address. In direct mode, interrupts also land on the base address. In vectored mode, an interrupt lands on the base plus four times its cause number. Cause 0, the user software interrupt, would share its vectored slot with exceptions. The user-level interrupt bits are therefore hardwired to zero, so that slot only ever receives exceptions.

Top module: `trap_vector_unit`

## Requirements
- R1: After a synchronous reset, the trap-vector base and mode, the enable register, the writable pending bit, `trap_taken`, `trap_cause`, `trap_pc` and `csr_rdata` are all zero.
- R2: A write to the trap-vector register (`csr_sel`=0) stores the written value with bits 1:0 cleared as the base. Bits 1:0 become the new mode if they are 0 (direct) or 1 (vectored). The values 2 and 3 leave the previous mode unchanged. A read returns base OR mode.
- R3: A write to the enable register (`csr_sel`=1) keeps only bits 1, 3, 7 and 11; every other bit, bit 0 included, reads as zero. For example, writing 0x8b reads back 0x8a.
- R4: The pending register (`csr_sel`=2) reads bit 11 = `irq_ext`, bit 7 = `irq_timer`, bit 3 = `irq_soft`, and bit 1 = a stored bit that CSR writes set or clear. Writes to all other bits are ignored, and bit 0 always reads zero.
- R5: An interrupt is taken only when its pending and enable bits are both 1 and `glob_ie` is 1.
- R6: When several interrupts qualify, the winner is cause 11, then 3, then 7, then 1.
- R7: An `exc_req` in a cycle takes the trap as an exception with cause `exc_cause`, regardless of any qualifying interrupt.
- R8: In direct mode (mode 0), both exceptions and interrupts set `trap_pc` to the base.
- R9: In vectored mode (mode 1), an exception sets `trap_pc` to the base, and an interrupt sets it to base + 4 × cause number.
- R10: `trap_cause` has bit XLEN-1 set for an interrupt and clear for an exception, with the cause number in the low bits.
- R11: The user software interrupt (cause 0) can never be pended, enabled or taken, so the vectored slot at the base serves only exceptions.
- R12: All outputs are registered. `trap_taken`, `trap_cause`, `trap_pc` and `csr_rdata` reflect the inputs and register state sampled at the previous rising edge, and `csr_rdata` shows the value held before any write in that cycle. `trap_cause` and `trap_pc` hold their values when no trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Write strobe for the selected register |
| csr_sel | input | 2 | Register select: 0 trap vector, 1 enable, 2 pending, 3 none |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Registered read data of the selected register |
| irq_timer | input | 1 | Machine timer interrupt line (cause 7) |
| irq_soft | input | 1 | Machine software interrupt line (cause 3) |
| irq_ext | input | 1 | Machine external interrupt line (cause 11) |
| glob_ie | input | 1 | Global machine interrupt enable |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | CODE_W | Exception cause number |
| trap_taken | output | 1 | One-cycle strobe per trap taken |
| trap_cause | output | XLEN | Cause of the last trap taken |
| trap_pc | output | XLEN | Handler start address of the last trap taken |

## Verification
The assertions assume that the inputs are stable around each rising edge and that `exc_cause` is a meaningful number whenever `exc_req` is high. They also assume that reset is held for at least one edge before any trap activity is judged. The stimulus changes every input only on the falling clock edge. It raises `exc_req` only with a defined cause, and it holds reset for two edges at the start. The per-cycle reference model tracks the same registers behaviourally, so every write, read and trap is compared in the cycle where its registered effect appears.

// File: rtl/tvu_pkg.sv
package tvu_pkg;

  typedef enum logic [1:0] {
    SEL_TVEC = 2'd0,
    SEL_IE   = 2'd1,
    SEL_IP   = 2'd2,
    SEL_NONE = 2'd3
  } csr_sel_e;

  localparam logic [1:0] MODE_DIRECT = 2'd0;
  localparam logic [1:0] MODE_VECTOR = 2'd1;

  localparam int CODE_USI = 0;
  localparam int CODE_SSI = 1;
  localparam int CODE_MSI = 3;
  localparam int CODE_MTI = 7;
  localparam int CODE_MEI = 11;

  localparam int NUM_IRQ = 4;
  // highest priority first
  localparam int IRQ_CODE [NUM_IRQ] = '{CODE_MEI, CODE_MSI, CODE_MTI, CODE_SSI};

endpackage

// File: rtl/tvu_csr_file.sv
module tvu_csr_file
  import tvu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csr_we,
  input  logic [1:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            irq_timer,
  input  logic            irq_soft,
  input  logic            irq_ext,
  output logic [XLEN-1:0] base_addr,
  output logic            vec_mode,
  output logic [XLEN-1:0] ie_vec,
  output logic [XLEN-1:0] ip_vec,
  output logic [XLEN-1:0] csr_rdata
);

  function automatic logic [XLEN-1:0] build_mask();
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_IRQ; i++) m[IRQ_CODE[i]] = 1'b1;
    return m;
  endfunction

  localparam logic [XLEN-1:0] IRQ_MASK = build_mask();

  logic [XLEN-3:0] base_q;
  logic [1:0]      mode_q;
  logic [XLEN-1:0] ie_q;
  logic            ssip_q;

  assign base_addr = {base_q, 2'b00};
  assign vec_mode  = (mode_q == MODE_VECTOR);
  assign ie_vec    = ie_q;

  always_comb begin
    ip_vec           = '0;
    ip_vec[CODE_SSI] = ssip_q;
    ip_vec[CODE_MSI] = irq_soft;
    ip_vec[CODE_MTI] = irq_timer;
    ip_vec[CODE_MEI] = irq_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mode_q <= MODE_DIRECT;
      ie_q   <= '0;
      ssip_q <= 1'b0;
    end else if (csr_we) begin
      case (csr_sel_e'(csr_sel))
        SEL_TVEC: begin
          base_q <= csr_wdata[XLEN-1:2];
          if (csr_wdata[1:0] == MODE_DIRECT || csr_wdata[1:0] == MODE_VECTOR)
            mode_q <= csr_wdata[1:0];
        end
        SEL_IE:  ie_q   <= csr_wdata & IRQ_MASK;
        SEL_IP:  ssip_q <= csr_wdata[CODE_SSI];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) csr_rdata <= '0;
    else begin
      case (csr_sel_e'(csr_sel))
        SEL_TVEC: csr_rdata <= {base_q, mode_q};
        SEL_IE:   csr_rdata <= ie_q;
        SEL_IP:   csr_rdata <= ip_vec;
        default:  csr_rdata <= '0;
      endcase
    end
  end

  // R2
  mode_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_sel == SEL_TVEC && csr_wdata[1]) |=> $stable(mode_q));

  // R4
  ip_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_sel != SEL_IP) |=> $stable(ssip_q));

endmodule

// File: rtl/tvu_irq_arbiter.sv
module tvu_irq_arbiter
  import tvu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   ie_vec,
  input  logic [XLEN-1:0]   ip_vec,
  input  logic              glob_ie,
  output logic              irq_valid,
  output logic [CODE_W-1:0] irq_code
);

  logic [XLEN-1:0] active;

  always_comb begin
    active    = ie_vec & ip_vec;
    irq_valid = 1'b0;
    irq_code  = '0;
    if (glob_ie) begin
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
        if (active[IRQ_CODE[i]]) begin
          irq_valid = 1'b1;
          irq_code  = CODE_W'(IRQ_CODE[i]);
        end
      end
    end
  end

  // R5
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !glob_ie |-> !irq_valid);

  // R6
  ext_first_chk: assert property (@(posedge clk) disable iff (rst)
    (glob_ie && ie_vec[CODE_MEI] && ip_vec[CODE_MEI]) |-> (irq_valid && irq_code == CODE_W'(CODE_MEI)));

endmodule

// File: rtl/tvu_trap_target.sv
module tvu_trap_target
  import tvu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_cause,
  input  logic              irq_valid,
  input  logic [CODE_W-1:0] irq_code,
  input  logic              glob_ie,
  input  logic [XLEN-1:0]   base_addr,
  input  logic              vec_mode,
  output logic              trap_taken,
  output logic [XLEN-1:0]   trap_cause,
  output logic [XLEN-1:0]   trap_pc
);

  localparam int PAD_W = XLEN - 1 - CODE_W;

  logic [XLEN-1:0] vec_offset;
  assign vec_offset = XLEN'(irq_code) << 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_taken <= 1'b0;
      trap_cause <= '0;
      trap_pc    <= '0;
    end else if (exc_req) begin
      trap_taken <= 1'b1;
      trap_cause <= {1'b0, {PAD_W{1'b0}}, exc_cause};
      trap_pc    <= base_addr;
    end else if (irq_valid) begin
      trap_taken <= 1'b1;
      trap_cause <= {1'b1, {PAD_W{1'b0}}, irq_code};
      trap_pc    <= vec_mode ? base_addr + vec_offset : base_addr;
    end else begin
      trap_taken <= 1'b0;
    end
  end

  // R7
  exc_wins_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> (trap_taken && !trap_cause[XLEN-1]));

  // R9
  exc_base_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> (trap_pc == $past(base_addr)));

  // R11
  no_usi_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_taken && trap_cause[XLEN-1]) |-> (trap_cause[CODE_W-1:0] != CODE_W'(CODE_USI)));

  // R5
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_taken && trap_cause[XLEN-1]) |-> $past(glob_ie));

endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
  import tvu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              irq_timer,
  input  logic              irq_soft,
  input  logic              irq_ext,
  input  logic              glob_ie,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_cause,
  output logic              trap_taken,
  output logic [XLEN-1:0]   trap_cause,
  output logic [XLEN-1:0]   trap_pc
);

  logic [XLEN-1:0]   base_addr;
  logic              vec_mode;
  logic [XLEN-1:0]   ie_vec;
  logic [XLEN-1:0]   ip_vec;
  logic              irq_valid;
  logic [CODE_W-1:0] irq_code;

  tvu_csr_file #(.XLEN(XLEN)) u_csr (
    .clk       (clk),
    .rst       (rst),
    .csr_we    (csr_we),
    .csr_sel   (csr_sel),
    .csr_wdata (csr_wdata),
    .irq_timer (irq_timer),
    .irq_soft  (irq_soft),
    .irq_ext   (irq_ext),
    .base_addr (base_addr),
    .vec_mode  (vec_mode),
    .ie_vec    (ie_vec),
    .ip_vec    (ip_vec),
    .csr_rdata (csr_rdata)
  );

  tvu_irq_arbiter #(.XLEN(XLEN), .CODE_W(CODE_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .ie_vec    (ie_vec),
    .ip_vec    (ip_vec),
    .glob_ie   (glob_ie),
    .irq_valid (irq_valid),
    .irq_code  (irq_code)
  );

  tvu_trap_target #(.XLEN(XLEN), .CODE_W(CODE_W)) u_tgt (
    .clk        (clk),
    .rst        (rst),
    .exc_req    (exc_req),
    .exc_cause  (exc_cause),
    .irq_valid  (irq_valid),
    .irq_code   (irq_code),
    .glob_ie    (glob_ie),
    .base_addr  (base_addr),
    .vec_mode   (vec_mode),
    .trap_taken (trap_taken),
    .trap_cause (trap_cause),
    .trap_pc    (trap_pc)
  );

endmodule

// File: tb/sim_trap_vector_unit.sv
`timescale 1ns/1ps
module sim_trap_vector_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_sel = 2'd3;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        irq_timer = 1'b0, irq_soft = 1'b0, irq_ext = 1'b0;
  logic        glob_ie = 1'b0;
  logic        exc_req = 1'b0;
  logic [3:0]  exc_cause = '0;
  logic        trap_taken;
  logic [31:0] trap_cause, trap_pc;

  always #4 clk = ~clk;

  trap_vector_unit u0 (.*);

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  // behavioural reference state
  logic [31:0] m_base = 0, m_en = 0;
  int          m_mode = 0;
  bit          m_ssip = 0;
  bit          e_taken = 0;
  logic [31:0] e_cause = 0, e_pc = 0, e_rd = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    logic [31:0] pend, act;
    int pri [4] = '{11, 3, 7, 1};
    int win;
    @(posedge clk);
    pend = 0;
    if (irq_ext)   pend |= 32'h800;
    if (irq_timer) pend |= 32'h80;
    if (irq_soft)  pend |= 32'h8;
    if (m_ssip)    pend |= 32'h2;
    if (rst) begin
      m_base = 0; m_mode = 0; m_en = 0; m_ssip = 0;
      e_taken = 0; e_cause = 0; e_pc = 0; e_rd = 0;
    end else begin
      case (csr_sel)
        2'd0: e_rd = m_base | m_mode;
        2'd1: e_rd = m_en;
        2'd2: e_rd = pend;
        default: e_rd = 0;
      endcase
      act = pend & m_en;
      win = -1;
      if (glob_ie)
        for (int i = 3; i >= 0; i--) if (act[pri[i]]) win = pri[i];
      if (exc_req) begin
        e_taken = 1; e_cause = {28'd0, exc_cause}; e_pc = m_base;
      end else if (win >= 0) begin
        e_taken = 1; e_cause = 32'h8000_0000 | win;
        e_pc = (m_mode == 1) ? m_base + 4 * win : m_base;
      end else e_taken = 0;
      if (csr_we) begin
        if (csr_sel == 2'd0) begin
          m_base = csr_wdata & ~32'h3;
          if (csr_wdata[1:0] < 2) m_mode = csr_wdata[1:0];
        end else if (csr_sel == 2'd1) m_en = csr_wdata & 32'h88A;
        else if (csr_sel == 2'd2) m_ssip = csr_wdata[1];
      end
    end
    @(negedge clk);
    chk("taken", {31'd0, trap_taken}, {31'd0, e_taken});
    chk("cause", trap_cause, e_cause);
    chk("pc",    trap_pc, e_pc);
    chk("rdata", csr_rdata, e_rd);
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    csr_we = 1; csr_sel = s; csr_wdata = d; step();
    csr_we = 0; csr_sel = 2'd3;
  endtask

  task automatic rd(logic [1:0] s, logic [31:0] exp);
    csr_sel = s; step();
    chk("readback", csr_rdata, exp);
    csr_sel = 2'd3;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    @(negedge clk);
    tag = "R1"; step(); step();
    rst = 0; step();
    chk("reset pc", trap_pc, 32'h0);

    tag = "R2"; wr(2'd0, 32'h0000_1003); rd(2'd0, 32'h0000_1000);
    wr(2'd0, 32'h0000_2001); rd(2'd0, 32'h0000_2001);
    wr(2'd0, 32'h0000_2002); rd(2'd0, 32'h0000_2001);

    tag = "R3"; wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, 32'h0000_088A);
    wr(2'd1, 32'h0000_008B); rd(2'd1, 32'h0000_008A);

    tag = "R4"; wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, 32'h0000_0002);
    irq_timer = 1; irq_soft = 1; irq_ext = 1; rd(2'd2, 32'h0000_088A);
    irq_timer = 0; irq_soft = 0; irq_ext = 0;

    tag = "R5"; step(); chk("no trap while gated", {31'd0, trap_taken}, 32'd0);
    glob_ie = 1; step();
    tag = "R9"; chk("ssi vector", trap_pc, 32'h0000_2004);
    tag = "R10"; chk("irq cause", trap_cause, 32'h8000_0001);

    tag = "R6"; irq_timer = 1; step(); chk("timer over ssi", trap_pc, 32'h0000_201C);
    irq_soft = 1; step(); chk("soft over timer", trap_pc, 32'h0000_200C);
    wr(2'd1, 32'h0000_088A); irq_ext = 1; step(); chk("ext first", trap_cause, 32'h8000_000B);
    chk("ext vector", trap_pc, 32'h0000_202C);

    tag = "R7"; exc_req = 1; exc_cause = 4'd2; step();
    chk("exc cause", trap_cause, 32'h0000_0002);
    tag = "R9"; chk("exc to base", trap_pc, 32'h0000_2000);
    exc_req = 0;

    tag = "R8"; wr(2'd0, 32'h0000_4000); step(); chk("direct irq", trap_pc, 32'h0000_4000);
    exc_req = 1; exc_cause = 4'd11; step(); chk("direct exc", trap_pc, 32'h0000_4000);
    exc_req = 0;

    tag = "R12"; irq_ext = 0; irq_soft = 0; irq_timer = 0; wr(2'd2, 32'h0);
    step(); step();
    chk("hold pc", trap_pc, e_pc);
    chk("no strobe", {31'd0, trap_taken}, 32'd0);

    tag = "R11"; wr(2'd0, 32'h0000_3001);
    wr(2'd1, 32'h0000_0001); wr(2'd2, 32'h0000_0001); step();
    chk("no usi trap", {31'd0, trap_taken}, 32'd0);
    rd(2'd1, 32'h0); rd(2'd2, 32'h0);

    for (int k = 0; k < 40; k++) begin
      tag = "R6";
      irq_timer = k[0]; irq_soft = k[1]; irq_ext = k[2];
      glob_ie = (k % 5) != 0; exc_req = (k % 7) == 3; exc_cause = k[3:0];
      if (k == 10) wr(2'd1, 32'h0000_088A);
      if (k == 20) wr(2'd2, 32'h0000_0002);
      if (k == 30) wr(2'd0, 32'h0000_5000);
      step();
    end
    exc_req = 0;

    tag = "R1"; rst = 1; step(); rst = 0; rd(2'd1, 32'h0);
    finish_up();
  end

endmodule